// File: doc/BRIEF.md
# Dual-Space Data Memory Read Router

This block sits between the address generation logic of a 16-bit DSP-capable processor and its data RAM. Each cycle it takes one access described by the pointer register number, the instruction class (plain MCU or dual-operand DSP), the direction and a 16-bit byte address. It returns the region that address falls in, a flag that tells the read path to substitute zero for the RAM data, and an address error trap. The results are registered, so they line up with read data that comes back one cycle after the address.

The 64 KB data space starts with a special function register area at 0x0000–0x07FF, followed by an X RAM region and a Y RAM region whose limits are elaboration parameters. Writes of any class and MCU reads through any pointer see SFR, X and Y as one linear space. Dual-operand DSP reads are tied to fixed pointer pairs, and each pair may only read its own port. A read through the X pair into Y, or through the Y pair into X or SFR space, returns zero. A DSP operand read that reaches an unimplemented address raises a trap instead.

A direct access (the near mode) supplies a 13-bit absolute address field, which is zero-extended, so it reaches only 0x0000–0x1FFF. If the region parameters overlap, elaboration fails.

Top module: `dsmem_route`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `rsp_valid`, `rsp_zero` and `rsp_trap` are 0, `rsp_rgn` is 0 and `rsp_addr` is 0.
- R2: An access presented with `acc_valid` high appears on the outputs exactly one clock later with `rsp_valid` high and `rsp_addr` equal to its effective address.
- R3: `rsp_rgn` encodes the region of the effective address: 2'b00 = SFR (0x0000–0x07FF), 2'b01 = X (0x0800–0x17FF by default), 2'b10 = Y (0x1800–0x27FF by default), 2'b11 = unimplemented (everything else).
- R4: A write (`acc_wr` = 1) of either class and through any pointer, including write-back through W13, uses the combined space and never sets `rsp_zero` or `rsp_trap`.
- R5: An MCU-class read (`acc_dsp` = 0) through any of the sixteen pointers uses the combined space and never sets `rsp_zero` or `rsp_trap`, even at an unimplemented address.
- R6: A DSP read through pointer 8 or 9 returns data (`rsp_zero` = 0) in SFR or X space and sets `rsp_zero` in Y space.
- R7: A DSP read through pointer 10 or 11 returns data in Y space and sets `rsp_zero` in SFR or X space.
- R8: A DSP read through pointers 8 to 11 to an unimplemented address sets `rsp_trap` and leaves `rsp_zero` at 0. `rsp_zero` and `rsp_trap` are never both set.
- R9: A DSP read through any pointer other than 8 to 11 sets `rsp_trap`.
- R10: With `acc_near` = 1, the effective address is bits 12:0 of `acc_addr` zero-extended to 16 bits, so it always lies below 0x2000.
- R11: One clock after a cycle with `acc_valid` low, `rsp_valid`, `rsp_zero` and `rsp_trap` are 0, and `rsp_rgn` and `rsp_addr` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_ptr | input | 4 | Number of the pointer register that holds the address |
| acc_dsp | input | 1 | 1 = dual-operand DSP class, 0 = MCU class |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_near | input | 1 | 1 = direct access through the 13-bit absolute field |
| acc_addr | input | 16 | Byte address |
| rsp_valid | output | 1 | Registered result is valid |
| rsp_rgn | output | 2 | Region of the effective address |
| rsp_zero | output | 1 | Read path substitutes zero for RAM data |
| rsp_trap | output | 1 | Address error trap |
| rsp_addr | output | 16 | Registered effective address |

## Verification
The assertions assume that every input is a known value on each rising edge and that the region parameters keep their default, non-overlapping layout. The port rules in the checker also assume the pointer pairs keep their default numbers 8/9 and 10/11. The bench changes its inputs only on falling edges and draws every field from defined values. The addresses it uses are weighted toward both edges of each region, the pointer numbers toward the four DSP pointers and W13, and the near flag is set together with high address bits so that the truncation is visible.

// File: rtl/dsmem_pkg.sv
package dsmem_pkg;

  // Region code carried on rsp_rgn
  typedef enum logic [1:0] {
    RGN_SFR  = 2'b00,
    RGN_X    = 2'b01,
    RGN_Y    = 2'b10,
    RGN_NONE = 2'b11
  } rgn_e;

  // Per-access result before the output register
  typedef struct packed {
    logic valid;
    rgn_e rgn;
    logic zero;
    logic trap;
  } rsp_flags_s;

  localparam int NUM_RANGES = 3;  // SFR, X, Y

endpackage

// File: rtl/dsmem_ea.sv
module dsmem_ea #(
  parameter int AW     = 16,
  parameter int NEAR_W = 13
) (
  input  logic          near,
  input  logic [AW-1:0] addr,
  output logic [AW-1:0] ea
);

  localparam int PAD_W = AW - NEAR_W;

  // Direct accesses carry only a short absolute field; widen it with zeros
  always_comb begin
    if (near) ea = {{PAD_W{1'b0}}, addr[NEAR_W-1:0]};
    else      ea = addr;
  end

endmodule

// File: rtl/dsmem_decode.sv
module dsmem_decode import dsmem_pkg::*; #(
  parameter int            AW      = 16,
  parameter logic [AW-1:0] SFR_TOP = AW'('h07FF),
  parameter logic [AW-1:0] XLO     = AW'('h0800),
  parameter logic [AW-1:0] XHI     = AW'('h17FF),
  parameter logic [AW-1:0] YLO     = AW'('h1800),
  parameter logic [AW-1:0] YHI     = AW'('h27FF)
) (
  input  logic [AW-1:0] ea,
  output rgn_e          rgn
);

  logic [NUM_RANGES-1:0] hit;

  // One window comparator per implemented range; offset compare wraps
  // below the lower bound, so one unsigned test covers both limits.
  for (genvar i = 0; i < NUM_RANGES; i++) begin : g_rng
    localparam logic [AW-1:0] LO = (i == 0) ? '0      : (i == 1) ? XLO : YLO;
    localparam logic [AW-1:0] HI = (i == 0) ? SFR_TOP : (i == 1) ? XHI : YHI;
    localparam logic [AW-1:0] SPAN = HI - LO;
    logic [AW-1:0] off;
    assign off    = ea - LO;
    assign hit[i] = (off <= SPAN);
  end

  always_comb begin
    rgn = RGN_NONE;
    if (hit[2]) rgn = RGN_Y;
    if (hit[1]) rgn = RGN_X;
    if (hit[0]) rgn = RGN_SFR;
  end

endmodule

// File: rtl/dsmem_policy.sv
module dsmem_policy import dsmem_pkg::*; #(
  parameter int            PW  = 4,
  parameter logic [PW-1:0] XP0 = PW'(8),
  parameter logic [PW-1:0] XP1 = PW'(9),
  parameter logic [PW-1:0] YP0 = PW'(10),
  parameter logic [PW-1:0] YP1 = PW'(11)
) (
  input  logic          valid,
  input  logic          dsp,
  input  logic          wr,
  input  logic [PW-1:0] ptr,
  input  rgn_e          rgn,
  output rsp_flags_s    flags
);

  logic x_port;
  logic y_port;
  logic split_rd;

  assign x_port   = (ptr == XP0) || (ptr == XP1);
  assign y_port   = (ptr == YP0) || (ptr == YP1);
  assign split_rd = dsp && !wr;

  always_comb begin
    flags       = '0;
    flags.rgn   = RGN_SFR;
    if (valid) begin
      flags.valid = 1'b1;
      flags.rgn   = rgn;
      if (split_rd) begin
        if (!x_port && !y_port) begin
          flags.trap = 1'b1;
        end else if (rgn == RGN_NONE) begin
          flags.trap = 1'b1;
        end else if (x_port) begin
          // X port sees SFR and X; Y returns zero
          flags.zero = (rgn == RGN_Y);
        end else begin
          // Y port sees only Y
          flags.zero = (rgn != RGN_Y);
        end
      end
    end
  end

endmodule

// File: rtl/dsmem_route.sv
module dsmem_route import dsmem_pkg::*; #(
  parameter int            AW      = 16,
  parameter int            NEAR_W  = 13,
  parameter int            PW      = 4,
  parameter logic [AW-1:0] SFR_TOP = AW'('h07FF),
  parameter logic [AW-1:0] XLO     = AW'('h0800),
  parameter logic [AW-1:0] XHI     = AW'('h17FF),
  parameter logic [AW-1:0] YLO     = AW'('h1800),
  parameter logic [AW-1:0] YHI     = AW'('h27FF),
  parameter logic [PW-1:0] XP0     = PW'(8),
  parameter logic [PW-1:0] XP1     = PW'(9),
  parameter logic [PW-1:0] YP0     = PW'(10),
  parameter logic [PW-1:0] YP1     = PW'(11)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc_valid,
  input  logic [PW-1:0] acc_ptr,
  input  logic          acc_dsp,
  input  logic          acc_wr,
  input  logic          acc_near,
  input  logic [AW-1:0] acc_addr,
  output logic          rsp_valid,
  output logic [1:0]    rsp_rgn,
  output logic          rsp_zero,
  output logic          rsp_trap,
  output logic [AW-1:0] rsp_addr
);

  // Elaboration-time map check: ranges ordered and disjoint
  localparam bit MAP_OK = (SFR_TOP < XLO) && (SFR_TOP < YLO) &&
                          (XLO <= XHI) && (YLO <= YHI) &&
                          ((XHI < YLO) || (YHI < XLO)) &&
                          (NEAR_W < AW);

  if (!MAP_OK) begin : g_bad_map
    $error("dsmem_route: region parameters overlap or are out of order");
  end

  logic [AW-1:0] ea;
  rgn_e          rgn;
  rsp_flags_s    flags_d;
  rsp_flags_s    flags_q;
  logic [AW-1:0] addr_q;

  dsmem_ea #(.AW(AW), .NEAR_W(NEAR_W)) u_ea (
    .near (acc_near),
    .addr (acc_addr),
    .ea   (ea)
  );

  dsmem_decode #(
    .AW(AW), .SFR_TOP(SFR_TOP), .XLO(XLO), .XHI(XHI), .YLO(YLO), .YHI(YHI)
  ) u_dec (
    .ea  (ea),
    .rgn (rgn)
  );

  dsmem_policy #(
    .PW(PW), .XP0(XP0), .XP1(XP1), .YP0(YP0), .YP1(YP1)
  ) u_pol (
    .valid (acc_valid),
    .dsp   (acc_dsp),
    .wr    (acc_wr),
    .ptr   (acc_ptr),
    .rgn   (rgn),
    .flags (flags_d)
  );

  // Output stage aligns the flags with the one-cycle RAM read
  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      addr_q  <= '0;
    end else begin
      flags_q <= flags_d;
      addr_q  <= acc_valid ? ea : '0;
    end
  end

  assign rsp_valid = flags_q.valid;
  assign rsp_rgn   = flags_q.rgn;
  assign rsp_zero  = flags_q.zero;
  assign rsp_trap  = flags_q.trap;
  assign rsp_addr  = addr_q;

endmodule

// File: rtl/dsmem_route_chk.sv
module dsmem_route_chk import dsmem_pkg::*; #(
  parameter int AW = 16,
  parameter int PW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          acc_valid,
  input logic [PW-1:0] acc_ptr,
  input logic          acc_dsp,
  input logic          acc_wr,
  input logic          acc_near,
  input logic [AW-1:0] acc_addr,
  input logic          rsp_valid,
  input logic [1:0]    rsp_rgn,
  input logic          rsp_zero,
  input logic          rsp_trap,
  input logic [AW-1:0] rsp_addr
);

  logic x_pair;
  logic y_pair;
  assign x_pair = (acc_ptr == PW'(8))  || (acc_ptr == PW'(9));
  assign y_pair = (acc_ptr == PW'(10)) || (acc_ptr == PW'(11));

  // R1: reset clears the outputs
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!rsp_valid && !rsp_zero && !rsp_trap && rsp_rgn == 2'b00 && rsp_addr == '0));

  // R2: one-cycle latency
  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> rsp_valid);

  // R11: idle cycle gives a quiet result
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> (!rsp_valid && !rsp_zero && !rsp_trap && rsp_addr == '0));

  // R4: writes never zero or trap
  p_write_linear_r4: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_wr) |=> (!rsp_zero && !rsp_trap));

  // R5: MCU reads never zero or trap
  p_mcu_linear_r5: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_dsp) |=> (!rsp_zero && !rsp_trap));

  // R6: X pair zeroes exactly in Y space
  p_xpair_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_dsp && !acc_wr && x_pair) |=> (rsp_zero == (rsp_rgn == 2'b10)));

  // R7: Y pair zeroes in SFR or X space
  p_ypair_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_dsp && !acc_wr && y_pair) |=>
      (rsp_zero == (rsp_rgn == 2'b00 || rsp_rgn == 2'b01)));

  // R8: unimplemented target of a DSP read traps
  p_unimpl_trap_r8: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_rgn == 2'b11 && $past(acc_dsp && !acc_wr)) |-> rsp_trap);

  // R8: zero and trap are exclusive
  p_flags_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(rsp_zero && rsp_trap));

  // R9: other pointers on a DSP read trap
  p_bad_ptr_trap_r9: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_dsp && !acc_wr && !x_pair && !y_pair) |=> rsp_trap);

  // R10: near accesses stay below 0x2000
  p_near_window_r10: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_near) |=> (rsp_addr < AW'('h2000)));

endmodule

bind dsmem_route dsmem_route_chk #(.AW(AW), .PW(PW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .acc_valid (acc_valid),
  .acc_ptr   (acc_ptr),
  .acc_dsp   (acc_dsp),
  .acc_wr    (acc_wr),
  .acc_near  (acc_near),
  .acc_addr  (acc_addr),
  .rsp_valid (rsp_valid),
  .rsp_rgn   (rsp_rgn),
  .rsp_zero  (rsp_zero),
  .rsp_trap  (rsp_trap),
  .rsp_addr  (rsp_addr)
);

// File: tb/dsmem_route_tb_top.sv
`timescale 1ns/1ps
module dsmem_route_tb_top;

  localparam int XLO = 'h0800, XHI = 'h17FF, YLO = 'h1800, YHI = 'h27FF;
  localparam int SFR_TOP = 'h07FF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 1'b0;
  logic [3:0]  acc_ptr = '0;
  logic        acc_dsp = 1'b0;
  logic        acc_wr = 1'b0;
  logic        acc_near = 1'b0;
  logic [15:0] acc_addr = '0;
  logic        rsp_valid;
  logic [1:0]  rsp_rgn;
  logic        rsp_zero;
  logic        rsp_trap;
  logic [15:0] rsp_addr;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  dsmem_route dut_i (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_ptr(acc_ptr),
    .acc_dsp(acc_dsp), .acc_wr(acc_wr), .acc_near(acc_near), .acc_addr(acc_addr),
    .rsp_valid(rsp_valid), .rsp_rgn(rsp_rgn), .rsp_zero(rsp_zero),
    .rsp_trap(rsp_trap), .rsp_addr(rsp_addr)
  );

  typedef struct {
    bit    v;
    int    rgn;
    bit    z;
    bit    t;
    int    addr;
    bit    near;
    string tag;
  } exp_t;

  exp_t exp_q[$];

  task automatic chk(string tag, string what, int act, int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Behavioural reference for one access
  function automatic exp_t model(bit v, int p, bit d, bit w, bit n, int a);
    exp_t e;
    int ea;
    e = '{v: 0, rgn: 0, z: 0, t: 0, addr: 0, near: 0, tag: "R11"};
    if (!v) return e;
    ea = n ? (a % 8192) : a;
    e.v = 1; e.addr = ea; e.near = n;
    if (ea <= SFR_TOP)                 e.rgn = 0;
    else if (ea >= XLO && ea <= XHI)   e.rgn = 1;
    else if (ea >= YLO && ea <= YHI)   e.rgn = 2;
    else                               e.rgn = 3;
    if (w)                             e.tag = "R4";
    else if (!d)                       e.tag = "R5";
    else if (p < 8 || p > 11) begin    e.tag = "R9"; e.t = 1; end
    else if (e.rgn == 3) begin         e.tag = "R8"; e.t = 1; end
    else if (p <= 9) begin             e.tag = "R6"; e.z = (e.rgn == 2); end
    else begin                         e.tag = "R7"; e.z = (e.rgn != 2); end
    return e;
  endfunction

  task automatic compare(exp_t e);
    chk(e.v ? "R2" : "R11", "valid", int'(rsp_valid), int'(e.v));
    chk(e.v ? "R3" : "R11", "region", int'(rsp_rgn), e.rgn);
    chk(e.near ? "R10" : (e.v ? "R2" : "R11"), "addr", int'(rsp_addr), e.addr);
    chk(e.tag, "zero", int'(rsp_zero), int'(e.z));
    chk(e.tag, "trap", int'(rsp_trap), int'(e.t));
  endtask

  task automatic step(bit v, int p, bit d, bit w, bit n, int a);
    @(negedge clk);
    if (exp_q.size() > 0) compare(exp_q.pop_front());
    acc_valid = v;
    acc_ptr   = 4'(p);
    acc_dsp   = d;
    acc_wr    = w;
    acc_near  = n;
    acc_addr  = 16'(a);
    exp_q.push_back(model(v, p, d, w, n, a));
  endtask

  function automatic int pick_addr();
    int edges[10] = '{'h0000, 'h07FF, 'h0800, 'h17FF, 'h1800,
                      'h27FF, 'h2800, 'h1FFF, 'h8000, 'hFFFF};
    if ($urandom_range(0, 1) == 0) return edges[$urandom_range(0, 9)];
    return int'($urandom_range(0, 'hFFFF));
  endfunction

  function automatic int pick_ptr();
    int r = int'($urandom_range(0, 7));
    if (r < 4) return 8 + r;
    if (r == 4) return 13;
    return int'($urandom_range(0, 15));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R2 watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "valid", int'(rsp_valid), 0);
    chk("R1", "region", int'(rsp_rgn), 0);
    chk("R1", "zero", int'(rsp_zero), 0);
    chk("R1", "trap", int'(rsp_trap), 0);
    chk("R1", "addr", int'(rsp_addr), 0);
    rst = 1'b0;

    // Directed corners
    step(1, 3,  0, 0, 0, 'h1000);  // R5 MCU read X
    step(1, 5,  0, 0, 0, 'h2000);  // R5 MCU read Y
    step(1, 7,  0, 0, 0, 'h3000);  // R5 MCU unimplemented, no trap
    step(1, 13, 1, 1, 0, 'h1F00);  // R4 write-back via W13 into Y
    step(1, 2,  1, 1, 0, 'h0400);  // R4 DSP write to SFR
    step(1, 8,  1, 0, 0, 'h0800);  // R6 X low edge
    step(1, 9,  1, 0, 0, 'h17FF);  // R6 X high edge
    step(1, 8,  1, 0, 0, 'h1800);  // R6 into Y -> zero
    step(1, 9,  1, 0, 0, 'h0100);  // R6 SFR allowed
    step(1, 10, 1, 0, 0, 'h1800);  // R7 Y low edge
    step(1, 11, 1, 0, 0, 'h27FF);  // R7 Y high edge
    step(1, 11, 1, 0, 0, 'h17FE);  // R7 into X -> zero
    step(1, 10, 1, 0, 0, 'h0010);  // R7 into SFR -> zero
    step(1, 11, 1, 0, 0, 'h2800);  // R8 past Y -> trap
    step(1, 8,  1, 0, 0, 'hFFFF);  // R8 top -> trap
    step(1, 4,  1, 0, 0, 'h1000);  // R9 wrong pointer
    step(1, 13, 1, 0, 0, 'h1800);  // R9 W13 on a DSP read
    step(1, 0,  0, 0, 1, 'hE123);  // R10 near truncation
    step(1, 10, 1, 0, 1, 'hF900);  // R10 near into Y
    step(0, 9,  1, 0, 0, 'h1800);  // R11 idle
    step(1, 8,  1, 0, 0, 'h1800);  // R6 back-to-back after idle

    for (int i = 0; i < 4000; i++) begin
      step(($urandom_range(0, 7) != 0), pick_ptr(), 1'($urandom_range(0, 1)),
           ($urandom_range(0, 3) == 0), ($urandom_range(0, 5) == 0), pick_addr());
    end

    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule